// File: doc/BRIEF.md
# Calibrated One-Second Prescaler with Test Output

This block turns a 32768 Hz oscillator enable into a one-cycle tick once per second. The divider is split into a fast stage of 256 oscillator pulses and a slow stage that counts those stages. A signed five-bit calibration value corrects the rate digitally. The correction is applied in whole or half fast-stage periods to single seconds, following a repeating cycle of 64 minutes. The block counts its own seconds and minutes within that cycle from the corrected tick.

A second function drives an open-drain pin from the same control byte. With the frequency-test bit set, the pin carries a square wave at 1/64 of the oscillator rate, which is 512 Hz at the nominal input. This wave comes from its own small divider, so calibration never moves it. With the bit clear, the pin shows a static level chosen by software.

The divider sequencer has three states. HALT is held while the stop input is high. HALT goes to COUNT on the first cycle with stop low. COUNT goes to STRETCH when a lengthened second reaches its normal end. STRETCH goes back to COUNT after 128 further pulses. Any state goes to HALT while stop is high. HALT and COUNT count pulses in the same way.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While reset is low, the tick is low and the pin is released (pin_pull_low = 0), whatever the control byte holds. The control copy resets to frequency-test off and output level high.
- R2: An unmodified second lasts 256 × 2^HI_BITS oscillator pulses, where a pulse is a clock cycle with osc_en high. The tick is high for exactly one clock, in the cycle after the clock edge that took the last pulse of the second.
- R3: With control bit 5 = 1 (positive), a modified second is 256 pulses shorter than normal.
- R4: With control bit 5 = 0 (negative), a modified second is 128 pulses longer than normal.
- R5: The modified seconds are the first second (index 0) of each minute whose index within the cycle is below 2 × N. N is control bits 4:0, a minute is SEC_PER_MIN seconds, and a cycle is MIN_PER_CYCLE minutes. A magnitude of 0 modifies no second, whatever the sign.
- R6: Minutes with index MIN_PER_CYCLE−2 or higher are never modified, even when 2 × N is larger.
- R7: With control bit 6 = 1, the pin level changes after every 2^FT_HALF_BITS pulses (32 by default), starting from released after stop or reset. This timing ignores calibration and second boundaries.
- R8: With control bit 6 = 0, the pin is pulled low exactly when control bit 7 is 0. A control change reaches the pin after one clock edge.
- R9: While stop is high, no tick occurs and pulses are ignored. After release, counting starts a fresh second at second 0 of minute 0, and the test divider restarts with the pin level released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One oscillator pulse when high for a cycle |
| ctrl_byte | input | 8 | Control: [7] output level, [6] frequency test, [5] calibration sign, [4:0] magnitude |
| stop | input | 1 | Holds the dividers and cycle position cleared |
| tick_1hz | output | 1 | One-cycle pulse at the end of each corrected second |
| pin_pull_low | output | 1 | Open-drain enable: 1 pulls the pin low |

## Verification
If the fast or slow stage holds a wrong count, the next tick arrives early or late by a whole number of pulses. That shows within the current second. If the minute or second position is wrong, the damage stays hidden until a minute's first second is corrected or left alone by mistake. That can take up to a full correction cycle to appear, so the bench runs past a cycle wrap for both signs. If the test divider holds a wrong count, the pin edge moves within 32 pulses. Random gaps in osc_en make sure that clock cycles are never mistaken for pulses.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    // width of the fast stage, where corrections are applied
    localparam int STAGE_BITS = 8;
    // width of the calibration magnitude field
    localparam int CAL_BITS   = 5;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } div_state_e;

    typedef struct packed {
        logic                out_lvl;  // static pin level when test is off
        logic                ft_en;    // frequency-test enable
        logic                cal_pos;  // 1: shorten seconds, 0: lengthen
        logic [CAL_BITS-1:0] cal_mag;  // number of minute pairs corrected
    } ctrl_t;

    localparam ctrl_t CTRL_POR = '{out_lvl: 1'b1, ft_en: 1'b0, cal_pos: 1'b0, cal_mag: '0};

endpackage

// File: rtl/rcp_stage_div.sv
module rcp_stage_div
    import rcp_pkg::*;
#(
    parameter int HI_BITS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic osc_en,
    input  logic shorten,
    input  logic lengthen,
    output logic sec_end,
    output logic tick
);

    localparam int HI_COUNT = 1 << HI_BITS;
    localparam logic [HI_BITS-1:0] HI_FULL  = HI_BITS'(HI_COUNT - 1);
    localparam logic [HI_BITS-1:0] HI_SHORT = HI_BITS'(HI_COUNT - 2);
    localparam logic [STAGE_BITS-1:0] LO_LAST  = '1;
    localparam logic [STAGE_BITS-1:0] EXT_LAST = STAGE_BITS'((1 << (STAGE_BITS - 1)) - 1);

    div_state_e             st_q, st_d;
    logic [STAGE_BITS-1:0]  lo_q, lo_d;
    logic [HI_BITS-1:0]     hi_q, hi_d;
    logic [HI_BITS-1:0]     end_hi;

    assign end_hi = shorten ? HI_SHORT : HI_FULL;

    // next-state and counter logic
    always_comb begin
        st_d    = st_q;
        lo_d    = lo_q;
        hi_d    = hi_q;
        sec_end = 1'b0;
        unique case (st_q)
            ST_HALT, ST_COUNT: begin
                st_d = ST_COUNT;
                if (osc_en) begin
                    lo_d = lo_q + 1'b1;
                    if (lo_q == LO_LAST) begin
                        if (hi_q == end_hi) begin
                            hi_d = '0;
                            if (lengthen) begin
                                st_d = ST_STRETCH;
                            end else begin
                                sec_end = 1'b1;
                            end
                        end else begin
                            hi_d = hi_q + 1'b1;
                        end
                    end
                end
            end
            ST_STRETCH: begin
                if (osc_en) begin
                    if (lo_q == EXT_LAST) begin
                        lo_d    = '0;
                        sec_end = 1'b1;
                        st_d    = ST_COUNT;
                    end else begin
                        lo_d = lo_q + 1'b1;
                    end
                end
            end
            default: st_d = ST_HALT;
        endcase
        if (stop) begin
            st_d    = ST_HALT;
            lo_d    = '0;
            hi_d    = '0;
            sec_end = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HALT;
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            st_q <= st_d;
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= sec_end;
        end
    end

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !tick);

    // R4
    stretch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_STRETCH) |-> (lo_q == '0) && (hi_q == '0));

endmodule

// File: rtl/rcp_cycle_pos.sv
module rcp_cycle_pos
    import rcp_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop,
    input  logic                sec_end,
    input  logic                cal_pos,
    input  logic [CAL_BITS-1:0] cal_mag,
    output logic                shorten,
    output logic                lengthen
);

    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam int MIN_W = (MIN_PER_CYCLE > 1) ? $clog2(MIN_PER_CYCLE) : 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);
    localparam int ELIG = MIN_PER_CYCLE - 2;

    logic [SEC_W-1:0] sec_q;
    logic [MIN_W-1:0] min_q;
    logic [31:0]      min_w, lim_w;
    logic             mod_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (stop) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (sec_end) begin
            if (sec_q == SEC_LAST) begin
                sec_q <= '0;
                min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    assign min_w   = 32'(min_q);
    assign lim_w   = 32'(cal_mag) << 1;
    assign mod_now = (sec_q == '0) && (min_w < lim_w) && (min_w < 32'(ELIG));
    assign shorten  = mod_now && cal_pos;
    assign lengthen = mod_now && !cal_pos;

    // R5
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n || stop)
        (sec_end && (sec_q != SEC_LAST)) |=> (sec_q == SEC_W'($past(sec_q) + 1'b1)));

endmodule

// File: rtl/rcp_test_out.sv
module rcp_test_out #(
    parameter int FT_HALF_BITS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic osc_en,
    input  logic ft_en,
    input  logic out_lvl,
    output logic pull_low
);

    localparam logic [FT_HALF_BITS-1:0] FT_LAST = '1;

    logic [FT_HALF_BITS-1:0] ft_cnt;
    logic                    ft_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ft_cnt <= '0;
            ft_lvl <= 1'b1;
        end else if (stop) begin
            ft_cnt <= '0;
            ft_lvl <= 1'b1;
        end else if (osc_en) begin
            ft_cnt <= ft_cnt + 1'b1;
            if (ft_cnt == FT_LAST) begin
                ft_lvl <= !ft_lvl;
            end
        end
    end

    assign pull_low = ft_en ? !ft_lvl : !out_lvl;

    // R7
    ft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !stop) |=> $stable(ft_lvl));

endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
    import rcp_pkg::*;
#(
    parameter int HI_BITS       = 7,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int FT_HALF_BITS  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic [7:0] ctrl_byte,
    input  logic       stop,
    output logic       tick_1hz,
    output logic       pin_pull_low
);

    ctrl_t ctrl_q;
    logic  sec_end;
    logic  shorten;
    logic  lengthen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_POR;
        end else begin
            ctrl_q <= ctrl_t'(ctrl_byte);
        end
    end

    rcp_stage_div #(
        .HI_BITS (HI_BITS)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (stop),
        .osc_en   (osc_en),
        .shorten  (shorten),
        .lengthen (lengthen),
        .sec_end  (sec_end),
        .tick     (tick_1hz)
    );

    rcp_cycle_pos #(
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_CYCLE (MIN_PER_CYCLE)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (stop),
        .sec_end  (sec_end),
        .cal_pos  (ctrl_q.cal_pos),
        .cal_mag  (ctrl_q.cal_mag),
        .shorten  (shorten),
        .lengthen (lengthen)
    );

    rcp_test_out #(
        .FT_HALF_BITS (FT_HALF_BITS)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (stop),
        .osc_en   (osc_en),
        .ft_en    (ctrl_q.ft_en),
        .out_lvl  (ctrl_q.out_lvl),
        .pull_low (pin_pull_low)
    );

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tick_1hz);

endmodule

// File: tb/rtc_cal_prescaler_test.sv
module rtc_cal_prescaler_test;

    localparam int HB    = 2;
    localparam int SPM   = 2;
    localparam int MPC   = 8;
    localparam int FTB   = 5;
    localparam int BASE  = 256 * (1 << HB);
    localparam int FTLEN = 1 << FTB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic [7:0] ctrl_byte = 8'h40;
    logic       stop = 1'b0;
    logic       tick_1hz;
    logic       pin_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int    cnt = 0, ssec = 0, smin = 0, ftc = 0, seen = 0;
    bit    ftl = 1, exp_tick = 0, exp_pull = 0;
    int    mag = 0;
    bit    pos = 0, ft = 0, outb = 1;
    string tick_tag = "R1", pin_tag = "R1";

    rtc_cal_prescaler #(
        .HI_BITS(HB), .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC), .FT_HALF_BITS(FTB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ctrl_byte(ctrl_byte),
        .stop(stop), .tick_1hz(tick_1hz), .pin_pull_low(pin_pull_low)
    );

    always #10 clk = !clk;

    function automatic bit is_mod(int s, int m, int mg);
        return (s == 0) && (m < 2 * mg) && (m < MPC - 2);
    endfunction

    function automatic int sec_len(int s, int m, int mg, bit p);
        if (!is_mod(s, m, mg)) return BASE;
        return p ? BASE - 256 : BASE + 128;
    endfunction

    function automatic string len_tag(int s, int m, int mg, bit p);
        if (is_mod(s, m, mg)) return p ? "R3" : "R4";
        if (s == 0 && m >= MPC - 2 && 2 * mg > m) return "R6";
        if (s == 0) return "R5";
        return "R2";
    endfunction

    task automatic chk(input logic act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit osc, input bit stp, input bit inrst);
        @(negedge clk);
        chk(tick_1hz, exp_tick, tick_tag);
        chk(pin_pull_low, exp_pull, pin_tag);
        rst_n     = !inrst;
        osc_en    = osc;
        stop      = stp;
        ctrl_byte = {outb, ft, pos, 5'(mag)};
        exp_tick  = 0;
        tick_tag  = inrst ? "R1" : (stp ? "R9" : "R2");
        if (inrst || stp) begin
            cnt = 0; ssec = 0; smin = 0; ftc = 0; ftl = 1;
        end else if (osc) begin
            cnt++;
            ftc = (ftc + 1) % FTLEN;
            if (ftc == 0) ftl = !ftl;
            if (cnt == sec_len(ssec, smin, mag, pos)) begin
                exp_tick = 1;
                tick_tag = len_tag(ssec, smin, mag, pos);
                cnt = 0;
                seen++;
                if (ssec == SPM - 1) begin
                    ssec = 0;
                    smin = (smin + 1) % MPC;
                end else begin
                    ssec++;
                end
            end
        end
        if (inrst) begin
            exp_pull = 0; pin_tag = "R1";
        end else begin
            exp_pull = ft ? !ftl : !outb;
            pin_tag  = ft ? "R7" : "R8";
        end
    endtask

    // stop, load calibration, then run nsec corrected seconds and some extra cycles
    task automatic phase(input int m, input bit p, input int nsec, input int extra);
        mag = m; pos = p;
        for (int i = 0; i < 6; i++) step(1'($urandom % 2), 1'b1, 1'b0);
        seen = 0;
        while (seen < nsec) begin
            if ($urandom % 900 == 0) ft = !ft;
            if ($urandom % 600 == 0) outb = !outb;
            step(1'($urandom % 4 != 0), 1'b0, 1'b0);
        end
        for (int i = 0; i < extra; i++) step(1'($urandom % 4 != 0), 1'b0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        // R1: reset dominates a control byte asking for test mode and low level
        for (int i = 0; i < 8; i++) step(1'($urandom % 2), 1'b0, 1'b1);
        // R8: static level, both values
        ft = 0; outb = 0;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
        outb = 1;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
        // R5: magnitude zero with positive sign modifies nothing
        phase(0, 1'b1, 5, 200);
        // R3: positive, two minutes modified, run past the cycle wrap
        phase(1, 1'b1, 18, 300);
        // R4: negative, four minutes modified, past the wrap
        phase(2, 1'b0, 18, 300);
        // R6: saturated positive magnitude, minutes 6 and 7 untouched
        ft = 1;
        phase(31, 1'b1, 17, 0);
        // R6: negative magnitude exactly at the eligible limit
        phase(3, 1'b0, 17, 500);
        // R9: stop mid-second above, then random calibration
        phase(int'($urandom % 32), 1'($urandom % 2), 10, 0);
        step(1'b0, 1'b0, 1'b0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule